// File: doc/BRIEF.md
# Active Priority and Preemption Tracker

This block keeps the preemption state of one processor's interrupt interface. When an interrupt is taken, the block turns its 8-bit priority into a group priority by masking off the subpriority bits chosen by a binary point setting. It records the resulting preemption level as one bit in an active-priority vector, and makes that group priority the running priority. When a handler signals priority drop, the block retires the highest-priority active level and recomputes the running priority from what is left.

Secure (group 0) and non-secure (group 1) activations are kept in two separate 32-bit vectors. A non-secure request to drop the priority of a group-0 interrupt has no effect. The block does not decide whether an interrupt may be acknowledged, and it does not store pending or active state per interrupt.

The activate and drop strobes are single-cycle events. The block accepts one on every cycle, so there is no back-pressure and no ready signal. The sender simply must not expect a drop to be taken in a cycle that also carries an activation.

Top module: `actprio_tracker`

## Requirements
- R1: After reset, the running priority is 0xFF and both active vectors are zero.
- R2: The group priority is the interrupt priority with every bit at or below position bp cleared, where bp is the effective binary point. bp=0 keeps bits [7:1], bp=2 keeps bits [7:3], and bp=7 gives 0x00.
- R3: The effective binary point is the alias binary point minus one when groups are enabled, the common-binary-point control is low and the interrupt is group 1. An alias value of 0 gives 0. In every other case the effective binary point is the main binary point.
- R4: On an activation, the preemption level is the group priority shifted right by 3. Bit `level` is set in the non-secure vector when groups are enabled and the interrupt is group 1; otherwise it is set in the secure vector. The running priority equals the group priority from the next cycle.
- R5: A drop request that is a non-secure access for an interrupt that is not group 1 (group 0, or any interrupt while groups are disabled) changes nothing.
- R6: An accepted drop clears the lowest-numbered set bit of the OR of both vectors, in both vectors. The running priority becomes the next lowest set level times 8, or 0xFF if no bit remains.
- R7: When activate and drop are strobed in the same cycle, the activation is performed and the drop is discarded.
- R8: In a cycle with no strobe, the running priority and both vectors hold their values.
- R9: A drop while both vectors are empty leaves the running priority at 0xFF and the vectors at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_en | input | 1 | Interrupt groups enabled |
| cbpr | input | 1 | Common binary point: group 1 uses the main binary point |
| bpr | input | 3 | Main binary point |
| abpr | input | 3 | Alias binary point used by group 1 |
| act_vld | input | 1 | Activation strobe |
| act_prio | input | 8 | Priority of the interrupt being activated |
| act_grp1 | input | 1 | Activated interrupt is group 1 |
| drop_vld | input | 1 | Priority-drop strobe |
| drop_grp1 | input | 1 | Interrupt being completed is group 1 |
| drop_ns | input | 1 | Drop request is a non-secure access |
| run_prio | output | 8 | Running priority |
| apr_s | output | 32 | Secure active-priority vector, bit n = level n |
| apr_ns | output | 32 | Non-secure active-priority vector, bit n = level n |

## Verification
The checker enforces four properties on every cycle:
- an empty pair of vectors always comes with a running priority of 0xFF;
- an accepted drop removes exactly one bit from the combined vector;
- an ignored non-secure drop, or a cycle with no strobe, leaves all state unchanged;
- an activation always leaves a bit set.

Some behaviours can only be shown by the bench's scenarios:
- the exact masked group priority for each binary point, including the alias-minus-one path and its zero clamp;
- the bank chosen for each activation;
- the level picked as next running priority;
- the case where the same level is set in both vectors.

// File: rtl/actprio_pkg.sv
package actprio_pkg;

  typedef enum logic {
    BANK_S  = 1'b0,
    BANK_NS = 1'b1
  } bank_e;

  typedef struct packed {
    logic  take;
    logic  ignored;
  } drop_dec_t;

endpackage

// File: rtl/actprio_grpprio.sv
module actprio_grpprio
  import actprio_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int BP_W   = 3,
  parameter int MIN_BP = 2,
  parameter int LVL_W  = PRIO_W - MIN_BP - 1
) (
  input  logic              grp_en,
  input  logic              cbpr,
  input  logic [BP_W-1:0]   bpr,
  input  logic [BP_W-1:0]   abpr,
  input  logic [PRIO_W-1:0] prio,
  input  logic              grp1,
  output logic [PRIO_W-1:0] gprio,
  output logic [LVL_W-1:0]  level,
  output bank_e             bank
);

  logic [BP_W-1:0] eff_bp;

  // Group 1 with a separate binary point uses the alias value less one.
  always_comb begin
    if (grp_en && !cbpr && grp1) begin
      eff_bp = (abpr == '0) ? '0 : abpr - BP_W'(1);
    end else begin
      eff_bp = bpr;
    end
  end

  // Keep only the bits strictly above the binary point.
  always_comb begin
    for (int i = 0; i < PRIO_W; i++) begin
      gprio[i] = prio[i] && (i > int'(eff_bp));
    end
  end

  assign level = gprio[PRIO_W-1:MIN_BP+1];
  assign bank  = (grp_en && grp1) ? BANK_NS : BANK_S;

endmodule

// File: rtl/actprio_lsb.sv
module actprio_lsb #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);

  // Scan from the top so the lowest set position wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/actprio_tracker.sv
module actprio_tracker
  import actprio_pkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int BP_W   = 3,
  parameter int MIN_BP = 2,
  localparam int LVL_W = PRIO_W - MIN_BP - 1,
  localparam int NLVL  = 1 << LVL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grp_en,
  input  logic              cbpr,
  input  logic [BP_W-1:0]   bpr,
  input  logic [BP_W-1:0]   abpr,
  input  logic              act_vld,
  input  logic [PRIO_W-1:0] act_prio,
  input  logic              act_grp1,
  input  logic              drop_vld,
  input  logic              drop_grp1,
  input  logic              drop_ns,
  output logic [PRIO_W-1:0] run_prio,
  output logic [NLVL-1:0]   apr_s,
  output logic [NLVL-1:0]   apr_ns
);

  localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

  logic [PRIO_W-1:0] gprio;
  logic [LVL_W-1:0]  act_level;
  bank_e             act_bank;

  actprio_grpprio #(
    .PRIO_W (PRIO_W),
    .BP_W   (BP_W),
    .MIN_BP (MIN_BP),
    .LVL_W  (LVL_W)
  ) u_grpprio (
    .grp_en (grp_en),
    .cbpr   (cbpr),
    .bpr    (bpr),
    .abpr   (abpr),
    .prio   (act_prio),
    .grp1   (act_grp1),
    .gprio  (gprio),
    .level  (act_level),
    .bank   (act_bank)
  );

  logic [NLVL-1:0]  combined;
  logic [NLVL-1:0]  clr_mask;
  logic [NLVL-1:0]  remain;
  logic             top_found;
  logic [LVL_W-1:0] top_idx;
  logic             next_found;
  logic [LVL_W-1:0] next_idx;

  assign combined = apr_s | apr_ns;

  actprio_lsb #(.N(NLVL), .IW(LVL_W)) u_lsb_top (
    .vec   (combined),
    .found (top_found),
    .idx   (top_idx)
  );

  assign clr_mask = top_found ? (NLVL'(1) << top_idx) : '0;
  assign remain   = combined & ~clr_mask;

  actprio_lsb #(.N(NLVL), .IW(LVL_W)) u_lsb_next (
    .vec   (remain),
    .found (next_found),
    .idx   (next_idx)
  );

  logic [PRIO_W-1:0] next_rprio;
  drop_dec_t         drop_dec;

  assign next_rprio = next_found ? {next_idx, {(MIN_BP + 1){1'b0}}} : IDLE_PRIO;

  always_comb begin
    drop_dec.ignored = drop_ns && !(grp_en && drop_grp1);
    drop_dec.take    = drop_vld && !act_vld && !drop_dec.ignored && top_found;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_prio <= IDLE_PRIO;
      apr_s    <= '0;
      apr_ns   <= '0;
    end else if (act_vld) begin
      run_prio <= gprio;
      if (act_bank == BANK_NS) begin
        apr_ns[act_level] <= 1'b1;
      end else begin
        apr_s[act_level]  <= 1'b1;
      end
    end else if (drop_dec.take) begin
      run_prio <= next_rprio;
      apr_s    <= apr_s & ~clr_mask;
      apr_ns   <= apr_ns & ~clr_mask;
    end
  end

endmodule

// File: rtl/actprio_tracker_chk.sv
module actprio_tracker_chk #(
  parameter int PRIO_W = 8,
  parameter int BP_W   = 3,
  parameter int NLVL   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              grp_en,
  input logic              act_vld,
  input logic              act_grp1,
  input logic              drop_vld,
  input logic              drop_grp1,
  input logic              drop_ns,
  input logic [PRIO_W-1:0] run_prio,
  input logic [NLVL-1:0]   apr_s,
  input logic [NLVL-1:0]   apr_ns
);

  logic drop_blocked;
  assign drop_blocked = drop_ns && !(grp_en && drop_grp1);

  // R6, R9: nothing active means the idle running priority
  a_r6_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((apr_s | apr_ns) == '0) |-> (run_prio == '1));

  // R4: an activation always leaves a level recorded
  a_r4_act_records: assert property (@(posedge clk) disable iff (!rst_n)
    act_vld |=> ((apr_s | apr_ns) != '0));

  // R4: group 1 with groups enabled lands in the non-secure vector
  a_r4_ns_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vld && grp_en && act_grp1) |=> (apr_ns != '0));

  // R5: blocked non-secure drop changes nothing
  a_r5_ns_drop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_vld && !act_vld && drop_blocked) |=>
      ($stable(apr_s) && $stable(apr_ns) && $stable(run_prio)));

  // R6: an accepted drop retires exactly one combined level
  a_r6_drop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_vld && !act_vld && !drop_blocked && ((apr_s | apr_ns) != '0)) |=>
      ($countones(apr_s | apr_ns) + 1 == $countones($past(apr_s | apr_ns))));

  // R8: no strobe, no change
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_vld && !drop_vld) |=>
      ($stable(apr_s) && $stable(apr_ns) && $stable(run_prio)));

endmodule

bind actprio_tracker actprio_tracker_chk #(
  .PRIO_W (PRIO_W),
  .BP_W   (BP_W),
  .NLVL   (NLVL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .grp_en    (grp_en),
  .act_vld   (act_vld),
  .act_grp1  (act_grp1),
  .drop_vld  (drop_vld),
  .drop_grp1 (drop_grp1),
  .drop_ns   (drop_ns),
  .run_prio  (run_prio),
  .apr_s     (apr_s),
  .apr_ns    (apr_ns)
);

// File: tb/actprio_tracker_test.sv
`timescale 1ns/100ps
module actprio_tracker_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        grp_en, cbpr, act_vld, act_grp1, drop_vld, drop_grp1, drop_ns;
  logic [2:0]  bpr, abpr;
  logic [7:0]  act_prio;
  logic [7:0]  run_prio;
  logic [31:0] apr_s, apr_ns;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  actprio_tracker uut (
    .clk(clk), .rst_n(rst_n), .grp_en(grp_en), .cbpr(cbpr), .bpr(bpr), .abpr(abpr),
    .act_vld(act_vld), .act_prio(act_prio), .act_grp1(act_grp1),
    .drop_vld(drop_vld), .drop_grp1(drop_grp1), .drop_ns(drop_ns),
    .run_prio(run_prio), .apr_s(apr_s), .apr_ns(apr_ns)
  );

  // op: 0 idle, 1 activate, 2 drop, 3 both
  typedef struct packed {
    logic [1:0]  op;
    logic        ge;
    logic        cb;
    logic [2:0]  bp;
    logic [2:0]  abp;
    logic [7:0]  prio;
    logic        g1;
    logic        ns;
    logic [7:0]  e_rpr;
    logic [31:0] e_s;
    logic [31:0] e_ns;
  } row_t;

  localparam int NROWS = 16;
  localparam row_t TBL [NROWS] = '{
    '{2'd1, 1'b1, 1'b0, 3'd2, 3'd3, 8'h48, 1'b0, 1'b0, 8'h48, 32'h0000_0200, 32'h0000_0000}, // R2 bp2
    '{2'd1, 1'b1, 1'b0, 3'd2, 3'd3, 8'h2F, 1'b1, 1'b0, 8'h28, 32'h0000_0200, 32'h0000_0020}, // R3 alias-1
    '{2'd1, 1'b1, 1'b0, 3'd2, 3'd1, 8'h13, 1'b1, 1'b0, 8'h12, 32'h0000_0200, 32'h0000_0024}, // R2 bp0
    '{2'd1, 1'b1, 1'b1, 3'd4, 3'd1, 8'h0F, 1'b1, 1'b0, 8'h00, 32'h0000_0200, 32'h0000_0025}, // R3 common
    '{2'd2, 1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 1'b1, 8'h00, 32'h0000_0200, 32'h0000_0025}, // R5
    '{2'd2, 1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 1'b1, 1'b1, 8'h10, 32'h0000_0200, 32'h0000_0024},
    '{2'd2, 1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 1'b0, 8'h28, 32'h0000_0200, 32'h0000_0020},
    '{2'd3, 1'b1, 1'b0, 3'd7, 3'd0, 8'hFF, 1'b0, 1'b0, 8'h00, 32'h0000_0201, 32'h0000_0020}, // R2 bp7
    '{2'd0, 1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 32'h0000_0201, 32'h0000_0020},
    '{2'd2, 1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 1'b0, 8'h28, 32'h0000_0200, 32'h0000_0020},
    '{2'd1, 1'b0, 1'b0, 3'd1, 3'd5, 8'h9C, 1'b1, 1'b0, 8'h9C, 32'h0008_0200, 32'h0000_0020}, // R3 groups off
    '{2'd2, 1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 1'b0, 8'h48, 32'h0008_0200, 32'h0000_0000},
    '{2'd2, 1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 1'b0, 8'h98, 32'h0008_0000, 32'h0000_0000},
    '{2'd2, 1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 1'b0, 8'hFF, 32'h0000_0000, 32'h0000_0000},
    '{2'd2, 1'b1, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 1'b0, 8'hFF, 32'h0000_0000, 32'h0000_0000}, // R9
    '{2'd1, 1'b1, 1'b0, 3'd5, 3'd0, 8'h07, 1'b1, 1'b0, 8'h06, 32'h0000_0000, 32'h0000_0001}  // R3 clamp
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic ge, input logic cb,
                       input logic [2:0] bp, input logic [2:0] abp,
                       input logic [7:0] pr, input logic g1, input logic ns);
    @(negedge clk);
    act_vld   = op[0];
    drop_vld  = op[1];
    grp_en    = ge;
    cbpr      = cb;
    bpr       = bp;
    abpr      = abp;
    act_prio  = pr;
    act_grp1  = g1;
    drop_grp1 = g1;
    drop_ns   = ns;
    @(posedge clk);
    #1;
  endtask

  task automatic chk_state(input string tag, input logic [7:0] r,
                           input logic [31:0] s, input logic [31:0] n);
    chk({tag, " run_prio"}, {24'h0, run_prio}, {24'h0, r});
    chk({tag, " apr_s"}, apr_s, s);
    chk({tag, " apr_ns"}, apr_ns, n);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {grp_en, cbpr, act_vld, act_grp1, drop_vld, drop_grp1, drop_ns} = '0;
    bpr = '0; abpr = '0; act_prio = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_state("R1 reset", 8'hFF, 32'h0, 32'h0);

    for (int i = 0; i < NROWS; i++) begin
      string tag;
      case (TBL[i].op)
        2'd1:    tag = $sformatf("R4 row %0d", i);
        2'd2:    tag = $sformatf("R6 row %0d", i);
        2'd3:    tag = $sformatf("R7 row %0d", i);
        default: tag = $sformatf("R8 row %0d", i);
      endcase
      apply(TBL[i].op, TBL[i].ge, TBL[i].cb, TBL[i].bp, TBL[i].abp,
            TBL[i].prio, TBL[i].g1, TBL[i].ns);
      chk_state(tag, TBL[i].e_rpr, TBL[i].e_s, TBL[i].e_ns);
    end

    // R1: reset in mid-use clears everything
    @(negedge clk);
    act_vld = 1'b0; drop_vld = 1'b0; rst_n = 1'b0;
    @(posedge clk);
    #1;
    chk_state("R1 mid reset", 8'hFF, 32'h0, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R5: groups disabled, a non-secure drop is ignored even if marked group 1
    apply(2'd1, 1'b0, 1'b0, 3'd2, 3'd0, 8'h40, 1'b0, 1'b0);
    chk_state("R4 level8", 8'h40, 32'h0000_0100, 32'h0);
    apply(2'd2, 1'b0, 1'b0, 3'd2, 3'd0, 8'h00, 1'b1, 1'b1);
    chk_state("R5 groups off", 8'h40, 32'h0000_0100, 32'h0);
    apply(2'd2, 1'b0, 1'b0, 3'd2, 3'd0, 8'h00, 1'b0, 1'b0);
    chk_state("R6 secure drop", 8'hFF, 32'h0, 32'h0);

    // R6: same level held in both vectors is cleared from both
    apply(2'd1, 1'b1, 1'b0, 3'd2, 3'd3, 8'h40, 1'b0, 1'b0);
    apply(2'd1, 1'b1, 1'b0, 3'd2, 3'd3, 8'h40, 1'b1, 1'b0);
    chk_state("R4 both banks", 8'h40, 32'h0000_0100, 32'h0000_0100);
    apply(2'd2, 1'b1, 1'b0, 3'd2, 3'd3, 8'h00, 1'b0, 1'b0);
    chk_state("R6 both cleared", 8'hFF, 32'h0, 32'h0);

    // R8: several idle cycles hold the state
    apply(2'd1, 1'b1, 1'b0, 3'd3, 3'd0, 8'hB7, 1'b0, 1'b0);
    apply(2'd0, 1'b1, 1'b0, 3'd3, 3'd0, 8'h00, 1'b0, 1'b0);
    apply(2'd0, 1'b1, 1'b0, 3'd3, 3'd0, 8'h00, 1'b0, 1'b0);
    chk_state("R8 idle hold", 8'hB0, 32'h0040_0000, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule